// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the flag-producing arithmetic/logic slice of a small 8-bit datapath. For one of four operations it computes a result byte and a new flag byte in the same cycle, without a clock. The four operations are: exclusive-OR of the accumulator with an operand, compare by subtraction, increment of an operand, and decrement of an operand. It also tells the surrounding datapath whether the result is written back and where it goes: the accumulator or the memory location the operand came from.

Each operation has its own flag rule. Compare changes only the flags. Increment and decrement keep the incoming carry. Exclusive-OR uses the parity/overflow bit as an even-parity indicator. The flag byte computed for the current inputs is available combinationally. A clocked flag register captures it when a load strobe is given, so the sequencer decides when the status really changes.

Top module: `flagalu_top`

## Requirements
- R1: With op_sel = 2'b00 (exclusive-OR), result_out equals acc_in ^ opnd_in, wr_en is 1 and wr_dst is 0 (accumulator).
- R2: For exclusive-OR, the flags (bit 7 S, bit 6 Z, bit 4 H, bit 2 P/V, bit 1 N, bit 0 C) are set as follows: S is result bit 7, Z is set when the result is zero, H, N and C are 0, and P/V is 1 when the result has an even number of one bits.
- R3: With op_sel = 2'b01 (compare), wr_en is 0 and result_out shows acc_in − opnd_in modulo 256. Because nothing is written, the accumulator is left unchanged.
- R4: For compare, S and Z follow the difference and N is 1. H is set when acc_in[3:0] < opnd_in[3:0]. C is set when acc_in < opnd_in (unsigned). P/V is set when the signed difference falls outside −128..127.
- R5: With op_sel = 2'b10 (increment), result_out is opnd_in + 1 modulo 256, wr_en is 1 and wr_dst is 1 (memory). N is 0 and H is set when opnd_in[3:0] = 4'hF. P/V is set only for opnd_in = 8'h7F. S and Z follow the result.
- R6: With op_sel = 2'b11 (decrement), result_out is opnd_in − 1 modulo 256, wr_en is 1 and wr_dst is 1. N is 1 and H is set when opnd_in[3:0] = 4'h0. P/V is set only for opnd_in = 8'h80. S and Z follow the result.
- R7: For increment and decrement, flags_next bit 0 (C) equals flags_in bit 0. For every operation, flags_next bits 5 and 3 equal the same bits of flags_in.
- R8: flags_q is cleared to 8'h00 on a rising clock edge with rst_n low. On a rising edge with rst_n high, flags_q loads flags_next when flag_en is 1 and holds its value when flag_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Synchronous active-low reset of the flag register |
| op_sel | input | 2 | Operation: 00 exclusive-OR, 01 compare, 10 increment, 11 decrement |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Operand value |
| flags_in | input | 8 | Current flag byte (supplies carry and the pass-through bits) |
| flag_en | input | 1 | Load strobe for the flag register |
| result_out | output | 8 | Result byte |
| wr_en | output | 1 | Result write-back enable |
| wr_dst | output | 1 | Write-back destination: 0 accumulator, 1 memory |
| flags_next | output | 8 | Combinational new flag byte |
| flags_q | output | 8 | Registered flag byte |

## Verification
result_out, wr_en, wr_dst and flags_next are combinational, so they are due in the same cycle as the inputs. The bench checks them 1 ns after each drive, while flag_en is held low. This sweep covers every operation, all 256×256 operand pairs, and the incoming carry at both 0 and 1. flags_q changes only at the rising edge that follows a load or a reset. For it, inputs are driven at a falling edge and the register is checked at the next falling edge, half a period after the edge that is expected to update or hold it.

// File: rtl/flagalu_pkg.sv
// Package: shared types and flag bit positions for the 8-bit flag ALU.
// Assumes an 8-bit flag byte. Bit positions are fixed because downstream
// condition logic decodes them.
package flagalu_pkg;

    typedef enum logic [1:0] {
        OP_XOR = 2'b00,
        OP_CMP = 2'b01,
        OP_INC = 2'b10,
        OP_DEC = 2'b11
    } alu_op_e;

    localparam int FLG_S  = 7;
    localparam int FLG_Z  = 6;
    localparam int FLG_X5 = 5;
    localparam int FLG_H  = 4;
    localparam int FLG_X3 = 3;
    localparam int FLG_PV = 2;
    localparam int FLG_N  = 1;
    localparam int FLG_C  = 0;

    // Status produced by one execution unit before it is packed into a flag byte.
    typedef struct packed {
        logic s;
        logic z;
        logic h;
        logic pv;
        logic n;
        logic c;
    } alu_stat_t;

endpackage

// File: rtl/flagalu_logic.sv
// Module: exclusive-OR unit with its even-parity status.
// Assumes DATA_W >= 2. H, N and C are forced low; P/V carries the parity.
module flagalu_logic
    import flagalu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o,
    output alu_stat_t         stat_o
);

    logic [DATA_W-1:0] x_w;
    logic [DATA_W:0]   par_chain;

    assign x_w = a_i ^ b_i;

    // Build the parity as a ripple chain so the width follows DATA_W.
    assign par_chain[0] = 1'b0;
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_par
        assign par_chain[gi+1] = par_chain[gi] ^ x_w[gi];
    end

    // Pack the logic status: the parity flag is set for an even count of ones.
    always_comb begin
        stat_o    = '0;
        stat_o.s  = x_w[DATA_W-1];
        stat_o.z  = (x_w == '0);
        stat_o.pv = ~par_chain[DATA_W];
        stat_o.h  = 1'b0;
        stat_o.n  = 1'b0;
        stat_o.c  = 1'b0;
    end

    assign res_o = x_w;

endmodule

// File: rtl/flagalu_arith.sv
// Module: shared adder for compare, increment and decrement.
// Compare subtracts the operand from the accumulator. Increment and decrement
// add or subtract one from the operand. Carry/borrow out of the nibble
// boundary and out of the top bit, and signed overflow, are all taken from
// the same addition. The c field is the raw borrow/carry out of the top bit;
// the top module decides whether it is used.
module flagalu_arith
    import flagalu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    output logic [DATA_W-1:0] res_o,
    output alu_stat_t         stat_o
);

    localparam int MSB = DATA_W - 1;

    logic              sub_w;
    logic [DATA_W-1:0] x_w;
    logic [DATA_W-1:0] y_w;
    logic [DATA_W-1:0] y_eff;
    logic [DATA_W:0]   sum_w;
    logic [NIB_W:0]    lo_w;
    logic              ovf_w;

    // Select the adder operands and direction for the requested operation.
    always_comb begin
        sub_w = (op_i == OP_CMP) || (op_i == OP_DEC);
        if (op_i == OP_CMP) begin
            x_w = acc_i;
            y_w = opnd_i;
        end else begin
            x_w = opnd_i;
            y_w = DATA_W'(1);
        end
        y_eff = sub_w ? ~y_w : y_w;
    end

    // Full-width and low-nibble sums; subtraction adds the inverted operand plus one.
    always_comb begin
        sum_w = {1'b0, x_w} + {1'b0, y_eff} + {{DATA_W{1'b0}}, sub_w};
        lo_w  = {1'b0, x_w[NIB_W-1:0]} + {1'b0, y_eff[NIB_W-1:0]}
              + {{NIB_W{1'b0}}, sub_w};
    end

    // Signed overflow: the result sign disagrees with the sign the operands imply.
    always_comb begin
        if (sub_w)
            ovf_w = (x_w[MSB] != y_w[MSB]) && (sum_w[MSB] != x_w[MSB]);
        else
            ovf_w = (x_w[MSB] == y_w[MSB]) && (sum_w[MSB] != x_w[MSB]);
    end

    // Convert carries into borrows for subtraction and pack the status.
    always_comb begin
        stat_o    = '0;
        stat_o.s  = sum_w[MSB];
        stat_o.z  = (sum_w[DATA_W-1:0] == '0);
        stat_o.h  = sub_w ? ~lo_w[NIB_W] : lo_w[NIB_W];
        stat_o.pv = ovf_w;
        stat_o.n  = sub_w;
        stat_o.c  = sub_w ? ~sum_w[DATA_W] : sum_w[DATA_W];
    end

    assign res_o = sum_w[DATA_W-1:0];

endmodule

// File: rtl/flagalu_flagreg.sv
// Module: flag holding register with a load strobe.
// Synchronous active-low reset clears it to zero; without load it holds.
module flagalu_flagreg #(
    parameter int FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [FLAG_W-1:0] d_i,
    output logic [FLAG_W-1:0] q_o
);

    // Hold or update the stored flags on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else if (load_i)
            q_o <= d_i;
    end

endmodule

// File: rtl/flagalu_top.sv
// Module: 8-bit ALU top with write-back control and a registered flag byte.
// Chooses between the logic and arithmetic units, applies the rule for
// each operation (which flags are kept), and drives the write-back enable and
// destination. Assumes op_sel, acc_in, opnd_in and flags_in are stable
// around each rising edge where flag_en is high.
module flagalu_top
    import flagalu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NIB_W  = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic [7:0]        flags_in,
    input  logic              flag_en,
    output logic [DATA_W-1:0] result_out,
    output logic              wr_en,
    output logic              wr_dst,
    output logic [7:0]        flags_next,
    output logic [7:0]        flags_q
);

    localparam int FLAG_W = 8;

    alu_op_e           op_w;
    logic [DATA_W-1:0] log_res;
    logic [DATA_W-1:0] ari_res;
    alu_stat_t         log_stat;
    alu_stat_t         ari_stat;
    alu_stat_t         sel_stat;

    assign op_w = alu_op_e'(op_sel);

    flagalu_logic #(.DATA_W(DATA_W)) logic_i (
        .a_i    (acc_in),
        .b_i    (opnd_in),
        .res_o  (log_res),
        .stat_o (log_stat)
    );

    flagalu_arith #(.DATA_W(DATA_W), .NIB_W(NIB_W)) arith_i (
        .op_i   (op_w),
        .acc_i  (acc_in),
        .opnd_i (opnd_in),
        .res_o  (ari_res),
        .stat_o (ari_stat)
    );

    // Pick the result and status from the unit that owns this operation.
    always_comb begin
        if (op_w == OP_XOR) begin
            result_out = log_res;
            sel_stat   = log_stat;
        end else begin
            result_out = ari_res;
            sel_stat   = ari_stat;
        end
    end

    // Write-back: compare writes nothing; increment/decrement go back to memory.
    always_comb begin
        unique case (op_w)
            OP_XOR:  begin wr_en = 1'b1; wr_dst = 1'b0; end
            OP_CMP:  begin wr_en = 1'b0; wr_dst = 1'b0; end
            OP_INC:  begin wr_en = 1'b1; wr_dst = 1'b1; end
            default: begin wr_en = 1'b1; wr_dst = 1'b1; end
        endcase
    end

    // Pack the flag byte: pass through bits 5 and 3; keep carry for INC/DEC.
    always_comb begin
        flags_next          = flags_in;
        flags_next[FLG_S]   = sel_stat.s;
        flags_next[FLG_Z]   = sel_stat.z;
        flags_next[FLG_H]   = sel_stat.h;
        flags_next[FLG_PV]  = sel_stat.pv;
        flags_next[FLG_N]   = sel_stat.n;
        if ((op_w == OP_INC) || (op_w == OP_DEC))
            flags_next[FLG_C] = flags_in[FLG_C];
        else
            flags_next[FLG_C] = sel_stat.c;
    end

    flagalu_flagreg #(.FLAG_W(FLAG_W)) freg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (flag_en),
        .d_i    (flags_next),
        .q_o    (flags_q)
    );

endmodule

// File: rtl/flagalu_chk.sv
// Checker: port-level properties of flagalu_top, attached with bind.
module flagalu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] op_sel,
    input logic [7:0] opnd_in,
    input logic [7:0] flags_in,
    input logic       flag_en,
    input logic       wr_en,
    input logic       wr_dst,
    input logic [7:0] flags_next,
    input logic [7:0] flags_q
);

    // R1: exclusive-OR writes to the accumulator
    a_r1_xor_to_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b00) |-> (wr_en && !wr_dst));

    // R2: exclusive-OR clears H, N and C
    a_r2_xor_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b00) |-> (flags_next[4] == 1'b0 && flags_next[1] == 1'b0
                               && flags_next[0] == 1'b0));

    // R3: compare never writes back
    a_r3_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b01) |-> !wr_en);

    // R5: increment overflow only from 0x7F
    a_r5_inc_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b10) |-> (flags_next[2] == (opnd_in == 8'h7F)));

    // R6: decrement overflow only from 0x80
    a_r6_dec_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b11) |-> (flags_next[2] == (opnd_in == 8'h80)));

    // R7: carry kept by increment and decrement
    a_r7_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel[1] |-> (flags_next[0] == flags_in[0]));

    // R7: bits 5 and 3 pass through
    a_r7_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_next[5] == flags_in[5]) && (flags_next[3] == flags_in[3]));

    // R8: load on strobe
    a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
        flag_en |=> (flags_q == $past(flags_next)));

    // R8: hold without strobe
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_en |=> $stable(flags_q));

endmodule

bind flagalu_top flagalu_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_sel     (op_sel),
    .opnd_in    (opnd_in),
    .flags_in   (flags_in),
    .flag_en    (flag_en),
    .wr_en      (wr_en),
    .wr_dst     (wr_dst),
    .flags_next (flags_next),
    .flags_q    (flags_q)
);

// File: tb/flagalu_top_tb_top.sv
// Bench: exhaustive sweep of all operations and operand pairs, plus register checks.
module flagalu_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] op_sel = 2'b00;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] opnd_in = 8'h00;
    logic [7:0] flags_in = 8'h00;
    logic       flag_en = 1'b0;
    logic [7:0] result_out;
    logic       wr_en;
    logic       wr_dst;
    logic [7:0] flags_next;
    logic [7:0] flags_q;

    int n_vec  = 0;
    int n_miss = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    flagalu_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_sel     (op_sel),
        .acc_in     (acc_in),
        .opnd_in    (opnd_in),
        .flags_in   (flags_in),
        .flag_en    (flag_en),
        .result_out (result_out),
        .wr_en      (wr_en),
        .wr_dst     (wr_dst),
        .flags_next (flags_next),
        .flags_q    (flags_q)
    );

    // Reference model computed arithmetically from the requirements.
    function automatic logic [18:0] model(input logic [1:0] op, input int a,
                                          input int b, input logic [7:0] fi);
        int r; int d; int sa; int sb; logic s; logic z; logic h; logic pv;
        logic n; logic c; logic we; logic wd; int ones;
        case (op)
            2'b00: begin // R1 R2
                r = a ^ b; ones = 0;
                for (int k = 0; k < 8; k++) ones += (r >> k) & 1;
                h = 0; n = 0; c = 0; pv = (ones % 2 == 0); we = 1; wd = 0;
            end
            2'b01: begin // R3 R4
                d = a - b; r = (d + 256) % 256;
                sa = (a > 127) ? a - 256 : a; sb = (b > 127) ? b - 256 : b;
                h = ((a % 16) < (b % 16)); c = (a < b);
                pv = ((sa - sb) > 127) || ((sa - sb) < -128);
                n = 1; we = 0; wd = 0;
            end
            2'b10: begin // R5 R7
                r = (b + 1) % 256; h = ((b % 16) == 15); pv = (b == 127);
                n = 0; c = fi[0]; we = 1; wd = 1;
            end
            default: begin // R6 R7
                r = (b + 255) % 256; h = ((b % 16) == 0); pv = (b == 128);
                n = 1; c = fi[0]; we = 1; wd = 1;
            end
        endcase
        s = (r > 127); z = (r == 0);
        return {r[7:0], we, wd, s, z, fi[5], h, fi[3], pv, n, c, 1'b0};
    endfunction

    task automatic check_comb();
        logic [18:0] e;
        string tag;
        e = model(op_sel, int'(acc_in), int'(opnd_in), flags_in);
        n_vec++;
        case (op_sel)
            2'b00: tag = "R1 R2";
            2'b01: tag = "R3 R4";
            2'b10: tag = "R5";
            default: tag = "R6";
        endcase
        if ({result_out, wr_en, wr_dst} != e[18:9]) begin
            n_miss++;
            $display("FAIL %s op=%0d a=%h b=%h res/we/dst actual %h/%b/%b expected %h/%b/%b",
                     tag, op_sel, acc_in, opnd_in, result_out, wr_en, wr_dst,
                     e[18:11], e[10], e[9]);
        end else if (flags_next != e[8:1]) begin
            n_miss++;
            if ({flags_next[5], flags_next[3]} != {e[6], e[4]} || (op_sel[1] && flags_next[0] != e[1]))
                tag = "R7";
            $display("FAIL %s op=%0d a=%h b=%h fi=%h flags actual %h expected %h",
                     tag, op_sel, acc_in, opnd_in, flags_in, flags_next, e[8:1]);
        end
    endtask

    task automatic check_q(input logic [7:0] exp_q, input string what);
        n_vec++;
        if (flags_q !== exp_q) begin
            n_miss++;
            $display("FAIL R8 %s flags_q actual %h expected %h", what, flags_q, exp_q);
        end
    endtask

    // Watchdog: a hung run counts as a miscompare and still prints the summary.
    initial begin
        #1500000;
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        logic [7:0] saved;
        // R8: reset state
        repeat (3) @(negedge clk);
        check_q(8'h00, "after reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R1-style sweep: every operation, all pairs, carry at both values (R1 R2 R3 R4 R5 R6 R7).
        for (int op = 0; op < 4; op++) begin
            for (int cin = 0; cin < 2; cin++) begin
                for (int a = 0; a < 256; a++) begin
                    for (int b = 0; b < 256; b++) begin
                        op_sel   = op[1:0];
                        acc_in   = a[7:0];
                        opnd_in  = b[7:0];
                        flags_in = {a[3:0] ^ b[7:4], b[2:0], cin[0]};
                        #1;
                        check_comb();
                    end
                end
            end
        end

        // R8: load on strobe (compare 0x10 - 0x20 with pass-through bits set)
        @(negedge clk);
        op_sel = 2'b01; acc_in = 8'h10; opnd_in = 8'h20; flags_in = 8'h28;
        flag_en = 1'b1;
        @(negedge clk);
        flag_en = 1'b0;
        // 0x10-0x20 = 0xF0: S=1, Z=0, X5=1, H=0, X3=1, PV=0, N=1, C=1 -> 0xAB
        check_q(8'hAB, "load compare");
        saved = 8'hAB;

        // R8: hold while strobe low and inputs change
        op_sel = 2'b00; acc_in = 8'h55; opnd_in = 8'h55; flags_in = 8'h00;
        @(negedge clk);
        check_q(saved, "hold");

        // R8: load increment of 0x7F with carry in 1 -> 0x80: S, H, PV, C -> 0x95
        op_sel = 2'b10; opnd_in = 8'h7F; flags_in = 8'h01; flag_en = 1'b1;
        @(negedge clk);
        check_q(8'h95, "load increment");

        // R8: synchronous reset wins over the strobe
        rst_n = 1'b0;
        @(negedge clk);
        check_q(8'h00, "reset with strobe");
        rst_n = 1'b1; flag_en = 1'b0;
        @(negedge clk);
        check_q(8'h00, "after reset release");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule